// File: doc/BRIEF.md
# External Interrupt Line State Bank

This block holds the per-line state of a set of external interrupt inputs: an enable bit, a pending bit, an active bit and an 8-bit priority for each line. A word-wide register bus reaches that state. Enable and pending each have a set window and a clear window. A write of 1 sets or clears a bit, and a write of 0 leaves it unchanged. A read of either window returns the live bits. Active state can be read but not written over the bus. Priorities are packed four to a word.

The block also owns the input side of each line. A rising edge on a line input makes that line pending. When the handler for a line reports completion while the input is still high, the line is made pending again. Software can pend any line through a trigger register. The trigger is refused unless the requester is privileged or a user-pend configuration input is high. A separate priority resolver reads the enable, pending, active and priority outputs, and reports back which line was taken (acknowledge) and which handler finished (completion).

Read data is registered and appears on `bus_rdata` one clock after the read strobe. Writes take effect at the clock edge on which they are presented.

Top module: `irq_setclr_bank`

## Requirements
- R1: Enable bits are set by writing 1s to the set window at byte offset 0x100 + 4*w, and cleared by writing 1s to the clear window at 0x180 + 4*w. Bit i of word w is line 32*w+i. A 0 in the write data leaves that line's enable bit unchanged.
- R2: A read of a set window or of the matching clear window returns the current state bits of the 32 lines in that word, one clock after the read strobe.
- R3: Pending bits are set through the window at 0x200 + 4*w and cleared through the window at 0x280 + 4*w, with the same bit-to-line layout as R1.
- R4: The active window at 0x300 + 4*w is read-only. An acknowledge of line n sets its active bit and clears its pending bit. A completion of line n clears its active bit. When both name the same line in the same cycle, the acknowledge wins.
- R5: The priority word at 0x400 + 4*p holds lines 4p to 4p+3. Line 4p+b sits in bits [8b+7:8b]. The whole word is written at once.
- R6: For lines at or above NUM_LINES, state words and priority bytes read as zero, and bus writes and software triggers to them change nothing.
- R7: A 0-to-1 transition on a line input sets that line's pending bit on the next clock edge. An input held high does not pend the line again after its pending bit is cleared.
- R8: A completion of a line whose input is high in that cycle sets the line's pending bit again. With the input low, the pending bit stays clear.
- R9: A write to offset 0xF00 pends line wdata[8:0] only when bus_priv or cfg_user_pend is high. Otherwise the write has no effect.
- R10: A read of offset 0x004 returns NUM_LINES/32 - 1.
- R11: When a rising edge and a pending-clear write hit the same line in the same cycle, the line ends up pending.
- R12: After reset, all enable, pending and active bits, all priorities and the read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the block |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Requester is privileged |
| bus_rdata | output | 32 | Registered read data |
| cfg_user_pend | input | 1 | Lets unprivileged requesters use the software trigger |
| irq_in | input | NUM_LINES | Line inputs |
| ack_valid | input | 1 | Resolver took a line |
| ack_line | input | LINE_W | Line taken |
| done_valid | input | 1 | Handler finished |
| done_line | input | LINE_W | Line whose handler finished |
| enable_o | output | NUM_LINES | Enable bits |
| pending_o | output | NUM_LINES | Pending bits |
| active_o | output | NUM_LINES | Active bits |
| prio_o | output | 8*NUM_LINES | Priorities, line n at [8n+7:8n] |

## Verification
The bench goes after these corner cases:
- A line input held high after its pending bit is cleared. A design that detected level instead of edge would pend the line again at once.
- A rising edge that lands in the same cycle as a pending-clear write. If the clear won, the edge would be lost.
- A completion while the input is still high, and then one with the input low. A missing re-pend would drop a level that is still asserted.
- Software triggers that are refused for lack of privilege, that use wdata bits above bit 8, or that name a line that does not exist.
- Writes to the read-only active window and to words past the configured count. A design that let these through would corrupt neighbouring state or read back non-zero.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
   localparam int WORD_W  = 32;
   localparam int PRIO_W  = 8;
   localparam int MAX_LINES = 480;
   // address bits [11:6] select a 64-byte window
   localparam logic [5:0] RGN_EN_SET = 6'h04;
   localparam logic [5:0] RGN_EN_CLR = 6'h06;
   localparam logic [5:0] RGN_PD_SET = 6'h08;
   localparam logic [5:0] RGN_PD_CLR = 6'h0A;
   localparam logic [5:0] RGN_ACT    = 6'h0C;
   localparam logic [11:0] TYPE_OFF  = 12'h004;
   localparam logic [11:0] TRIG_OFF  = 12'hF00;
   localparam logic [9:0]  PRIO_SPAN = 10'h1F0;

   typedef enum logic [2:0] {
      SRC_NONE, SRC_EN, SRC_PD, SRC_ACT, SRC_PRIO, SRC_TYPE
   } rd_src_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_bank_pkg::*;
#(
   parameter int NUM_LINES = 64
) (
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [11:0]           bus_addr,
   input  logic [WORD_W-1:0]     bus_wdata,
   input  logic                  bus_priv,
   input  logic                  cfg_user_pend,
   output logic [NUM_LINES-1:0]  en_set,
   output logic [NUM_LINES-1:0]  en_clr,
   output logic [NUM_LINES-1:0]  pd_set,
   output logic [NUM_LINES-1:0]  pd_clr,
   output logic [NUM_LINES-1:0]  prio_we,
   output logic [NUM_LINES-1:0]  sw_pend
);
   logic       wr_cyc;
   logic [5:0] region;
   logic [3:0] word;
   logic [7:0] pword;
   logic       in_prio;
   logic       trig_ok;

   always_comb begin
      wr_cyc  = bus_sel && bus_wr;
      region  = bus_addr[11:6];
      word    = bus_addr[5:2];
      pword   = bus_addr[9:2];
      in_prio = (bus_addr[11:10] == 2'b01) && (bus_addr[9:0] < PRIO_SPAN);
      trig_ok = wr_cyc && (bus_addr == TRIG_OFF) && (bus_priv || cfg_user_pend);
   end

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      localparam int W = n / WORD_W;
      localparam int B = n % WORD_W;
      logic word_hit;
      assign word_hit   = (int'(word) == W) && bus_wdata[B];
      assign en_set[n]  = wr_cyc && (region == RGN_EN_SET) && word_hit;
      assign en_clr[n]  = wr_cyc && (region == RGN_EN_CLR) && word_hit;
      assign pd_set[n]  = wr_cyc && (region == RGN_PD_SET) && word_hit;
      assign pd_clr[n]  = wr_cyc && (region == RGN_PD_CLR) && word_hit;
      assign prio_we[n] = wr_cyc && in_prio && (int'(pword) == n / 4);
      assign sw_pend[n] = trig_ok && (int'(bus_wdata[8:0]) == n);
   end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
   import irq_bank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_in,
   input  logic              en_set,
   input  logic              en_clr,
   input  logic              pd_set,
   input  logic              pd_clr,
   input  logic              sw_pend,
   input  logic              ack_hit,
   input  logic              done_hit,
   input  logic              prio_we,
   input  logic [PRIO_W-1:0] prio_wdata,
   output logic              enable,
   output logic              pending,
   output logic              active,
   output logic [PRIO_W-1:0] prio
);
   logic level_q;
   logic rise;
   logic set_any;
   logic clr_any;

   always_comb begin
      rise    = line_in && !level_q;
      // every source that pends outranks every source that clears
      set_any = rise || (done_hit && line_in) || sw_pend || pd_set;
      clr_any = pd_clr || ack_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         enable  <= 1'b0;
         pending <= 1'b0;
         active  <= 1'b0;
         prio    <= '0;
      end else begin
         level_q <= line_in;
         if (en_set)       enable <= 1'b1;
         else if (en_clr)  enable <= 1'b0;
         if (set_any)      pending <= 1'b1;
         else if (clr_any) pending <= 1'b0;
         if (ack_hit)       active <= 1'b1;
         else if (done_hit) active <= 1'b0;
         if (prio_we)      prio <= prio_wdata;
      end
   end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import irq_bank_pkg::*;
#(
   parameter int NUM_LINES = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd_en,
   input  logic [11:0]                 rd_addr,
   input  logic [NUM_LINES-1:0]        enable,
   input  logic [NUM_LINES-1:0]        pending,
   input  logic [NUM_LINES-1:0]        active,
   input  logic [NUM_LINES*PRIO_W-1:0] prio,
   output logic [WORD_W-1:0]           rdata
);
   localparam int NUM_WORDS  = NUM_LINES / WORD_W;
   localparam int PRIO_WORDS = NUM_LINES / 4;

   rd_src_e           src;
   logic [WORD_W-1:0] en_w, pd_w, act_w, prio_w, rdata_d;

   always_comb begin
      src = SRC_NONE;
      if (rd_addr == TYPE_OFF)                                   src = SRC_TYPE;
      else if (rd_addr[11:6] == RGN_EN_SET || rd_addr[11:6] == RGN_EN_CLR) src = SRC_EN;
      else if (rd_addr[11:6] == RGN_PD_SET || rd_addr[11:6] == RGN_PD_CLR) src = SRC_PD;
      else if (rd_addr[11:6] == RGN_ACT)                          src = SRC_ACT;
      else if (rd_addr[11:10] == 2'b01 && rd_addr[9:0] < PRIO_SPAN) src = SRC_PRIO;
   end

   always_comb begin
      en_w = '0; pd_w = '0; act_w = '0; prio_w = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (int'(rd_addr[5:2]) == w) begin
            en_w  = enable[w*WORD_W +: WORD_W];
            pd_w  = pending[w*WORD_W +: WORD_W];
            act_w = active[w*WORD_W +: WORD_W];
         end
      end
      for (int p = 0; p < PRIO_WORDS; p++) begin
         if (int'(rd_addr[9:2]) == p) prio_w = prio[p*WORD_W +: WORD_W];
      end
   end

   always_comb begin
      unique case (src)
         SRC_TYPE: rdata_d = WORD_W'(NUM_WORDS - 1);
         SRC_EN:   rdata_d = en_w;
         SRC_PD:   rdata_d = pd_w;
         SRC_ACT:  rdata_d = act_w;
         SRC_PRIO: rdata_d = prio_w;
         default:  rdata_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rdata_d;
   end
endmodule

// File: rtl/irq_setclr_bank.sv
module irq_setclr_bank
   import irq_bank_pkg::*;
#(
   parameter int NUM_LINES = 64,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_sel,
   input  logic                        bus_wr,
   input  logic [11:0]                 bus_addr,
   input  logic [31:0]                 bus_wdata,
   input  logic                        bus_priv,
   output logic [31:0]                 bus_rdata,
   input  logic                        cfg_user_pend,
   input  logic [NUM_LINES-1:0]        irq_in,
   input  logic                        ack_valid,
   input  logic [LINE_W-1:0]           ack_line,
   input  logic                        done_valid,
   input  logic [LINE_W-1:0]           done_line,
   output logic [NUM_LINES-1:0]        enable_o,
   output logic [NUM_LINES-1:0]        pending_o,
   output logic [NUM_LINES-1:0]        active_o,
   output logic [NUM_LINES*8-1:0]      prio_o
);
   if (NUM_LINES % WORD_W != 0 || NUM_LINES < WORD_W || NUM_LINES > MAX_LINES) begin : g_bad_cfg
      $error("NUM_LINES must be a multiple of 32 between 32 and 480");
   end

   logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr, prio_we, sw_pend;

   irq_reg_decode #(.NUM_LINES(NUM_LINES)) u_dec (
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_priv(bus_priv), .cfg_user_pend(cfg_user_pend),
      .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
      .prio_we(prio_we), .sw_pend(sw_pend)
   );

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_cell
      logic ack_hit, done_hit;
      assign ack_hit  = ack_valid  && (ack_line  == LINE_W'(n));
      assign done_hit = done_valid && (done_line == LINE_W'(n));
      irq_line_cell u_cell (
         .clk(clk), .rst_n(rst_n), .line_in(irq_in[n]),
         .en_set(en_set[n]), .en_clr(en_clr[n]),
         .pd_set(pd_set[n]), .pd_clr(pd_clr[n]), .sw_pend(sw_pend[n]),
         .ack_hit(ack_hit), .done_hit(done_hit),
         .prio_we(prio_we[n]), .prio_wdata(bus_wdata[(n % 4)*PRIO_W +: PRIO_W]),
         .enable(enable_o[n]), .pending(pending_o[n]), .active(active_o[n]),
         .prio(prio_o[n*PRIO_W +: PRIO_W])
      );
   end

   irq_read_mux #(.NUM_LINES(NUM_LINES)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(bus_sel && !bus_wr), .rd_addr(bus_addr),
      .enable(enable_o), .pending(pending_o), .active(active_o), .prio(prio_o),
      .rdata(bus_rdata)
   );
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
   parameter int NUM_LINES = 64,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_sel,
   input logic                 bus_wr,
   input logic [11:0]          bus_addr,
   input logic [31:0]          bus_rdata,
   input logic [NUM_LINES-1:0] irq_in,
   input logic                 ack_valid,
   input logic [LINE_W-1:0]    ack_line,
   input logic                 done_valid,
   input logic [LINE_W-1:0]    done_line,
   input logic [NUM_LINES-1:0] enable_o,
   input logic [NUM_LINES-1:0] pending_o,
   input logic [NUM_LINES-1:0] active_o
);
   logic [NUM_LINES-1:0] prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= irq_in;
   end

   a_r1_enable_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> $stable(enable_o));

   a_r10_type_word: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == 12'h004) |=> (bus_rdata == 32'(NUM_LINES/32 - 1)));

   a_r4_active_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_valid && !done_valid) |=> $stable(active_o));

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
      // R7 and R11: an edge always leaves the line pending
      a_r7_edge_pends: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_in[n] && !prev_q[n]) |=> pending_o[n]);
      a_r4_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_valid && ack_line == LINE_W'(n)) |=> active_o[n]);
      a_r4_done_deactivates: assert property (@(posedge clk) disable iff (!rst_n)
         (done_valid && done_line == LINE_W'(n) && !(ack_valid && ack_line == LINE_W'(n)))
         |=> !active_o[n]);
      a_r8_repend_high: assert property (@(posedge clk) disable iff (!rst_n)
         (done_valid && done_line == LINE_W'(n) && irq_in[n]) |=> pending_o[n]);
   end
endmodule

bind irq_setclr_bank irq_bank_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_in(irq_in),
   .ack_valid(ack_valid), .ack_line(ack_line),
   .done_valid(done_valid), .done_line(done_line),
   .enable_o(enable_o), .pending_o(pending_o), .active_o(active_o)
);

// File: tb/sim_irq_setclr_bank.sv
module sim_irq_setclr_bank;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 64;
   localparam int LW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0, cfg_user_pend = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  irq_in = '0;
   logic          ack_valid = 1'b0, done_valid = 1'b0;
   logic [LW-1:0] ack_line = '0, done_line = '0;
   logic [N-1:0]  enable_o, pending_o, active_o;
   logic [N*8-1:0] prio_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_setclr_bank #(.NUM_LINES(N)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
      .bus_rdata(bus_rdata), .cfg_user_pend(cfg_user_pend), .irq_in(irq_in),
      .ack_valid(ack_valid), .ack_line(ack_line),
      .done_valid(done_valid), .done_line(done_line),
      .enable_o(enable_o), .pending_o(pending_o), .active_o(active_o), .prio_o(prio_o)
   );

   typedef struct {
      logic [11:0] addr;
      logic [31:0] exp;
      string       tag;
   } rd_item_t;

   rd_item_t sb_q[$];
   int n_checks = 0;
   int n_fail   = 0;
   logic rd_seen = 1'b0;

   always @(posedge clk) rd_seen <= bus_sel && !bus_wr;

   // monitor: read data is registered, so it is compared at the following falling edge
   always @(negedge clk) begin
      if (rd_seen) begin
         rd_item_t it;
         n_checks++;
         if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard: read data with no expected item, actual %h expected none", bus_rdata);
         end else begin
            it = sb_q.pop_front();
            if (bus_rdata !== it.exp) begin
               n_fail++;
               $display("FAIL %s: read %h actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
            end
         end
      end
   end

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic priv);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = priv;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
      rd_item_t it;
      @(negedge clk);
      it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic pulse_ack(input int ln);
      @(negedge clk);
      ack_valid = 1'b1; ack_line = LW'(ln);
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   task automatic pulse_done(input int ln);
      @(negedge clk);
      done_valid = 1'b1; done_line = LW'(ln);
      @(negedge clk);
      done_valid = 1'b0;
   endtask

   task automatic check_val(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12: reset state
      check_val(enable_o,  '0, "R12 enable");
      check_val(pending_o, '0, "R12 pending");
      check_val(active_o,  '0, "R12 active");
      check_val(prio_o[63:0], '0, "R12 prio");
      check_val(64'(bus_rdata), '0, "R12 rdata");
      bus_read(12'h100, 32'h0, "R12 enable word");
      bus_read(12'h300, 32'h0, "R12 active word");
      // R10
      bus_read(12'h004, 32'd1, "R10 type");
      // R1/R2: set enables, read both windows
      bus_write(12'h100, 32'h8000_0011, 1'b1);
      bus_read(12'h100, 32'h8000_0011, "R2 set window");
      bus_read(12'h180, 32'h8000_0011, "R2 clear window");
      bus_write(12'h104, 32'h0000_0001, 1'b1);
      bus_read(12'h184, 32'h0000_0001, "R1 word1 line32");
      bus_write(12'h180, 32'h0000_0010, 1'b1);
      bus_write(12'h100, 32'h0, 1'b1);
      bus_read(12'h100, 32'h8000_0001, "R1 clear line4, zero write no effect");
      check_val(enable_o, 64'h0000_0001_8000_0001, "R1 enable vector");
      // R3
      bus_write(12'h204, 32'h3, 1'b1);
      bus_read(12'h284, 32'h3, "R3 pend set");
      bus_write(12'h284, 32'h1, 1'b1);
      bus_read(12'h204, 32'h2, "R3 pend clear");
      // R6: words beyond the configured count
      bus_write(12'h108, 32'hFFFF_FFFF, 1'b1);
      bus_read(12'h108, 32'h0, "R6 enable word2");
      bus_read(12'h100, 32'h8000_0001, "R6 word0 untouched");
      bus_write(12'h440, 32'hFFFF_FFFF, 1'b1);
      bus_read(12'h440, 32'h0, "R6 prio line64");
      // R5
      bus_write(12'h404, 32'h4433_2211, 1'b1);
      bus_read(12'h404, 32'h4433_2211, "R5 prio word1");
      bus_read(12'h400, 32'h0, "R5 prio word0 untouched");
      check_val(64'(prio_o[5*8 +: 8]), 64'h22, "R5 line5 byte");
      check_val(64'(prio_o[7*8 +: 8]), 64'h44, "R5 line7 byte");
      // R7: rising edge pends, held level does not re-pend
      @(negedge clk); irq_in[3] = 1'b1;
      @(negedge clk);
      check_val(64'(pending_o[3]), 64'd1, "R7 edge pends");
      bus_write(12'h280, 32'h8, 1'b1);
      bus_read(12'h200, 32'h0, "R7 held high no re-pend");
      // R11: edge and clear together
      @(negedge clk);
      irq_in[5] = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h280; bus_wdata = 32'h20; bus_priv = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
      bus_read(12'h200, 32'h20, "R11 edge beats clear");
      // R4/R8
      pulse_ack(5);
      bus_read(12'h300, 32'h20, "R4 ack activates");
      bus_read(12'h200, 32'h0,  "R4 ack clears pending");
      bus_write(12'h300, 32'hFFFF_FFFF, 1'b1);
      bus_read(12'h300, 32'h20, "R4 active read-only");
      pulse_done(5);
      bus_read(12'h200, 32'h20, "R8 re-pend while high");
      bus_read(12'h300, 32'h0,  "R4 done deactivates");
      @(negedge clk); irq_in[5] = 1'b0;
      pulse_ack(5);
      pulse_done(5);
      bus_read(12'h200, 32'h0, "R8 no re-pend when low");
      check_val(active_o, '0, "R4 all inactive");
      // R9: software trigger
      bus_write(12'hF00, 32'd10, 1'b0);
      bus_read(12'h200, 32'h0, "R9 unprivileged refused");
      bus_write(12'hF00, 32'd10, 1'b1);
      bus_read(12'h200, 32'h400, "R9 privileged line10");
      bus_write(12'hF00, 32'h20B, 1'b1);
      bus_read(12'h200, 32'hC00, "R9 only low 9 bits used");
      @(negedge clk); cfg_user_pend = 1'b1;
      bus_write(12'hF00, 32'd40, 1'b0);
      bus_read(12'h204, 32'h102, "R9 user pend allowed");
      @(negedge clk); cfg_user_pend = 1'b0;
      bus_write(12'hF00, 32'd64, 1'b1);
      bus_read(12'h200, 32'hC00, "R6 trigger beyond lines word0");
      bus_read(12'h204, 32'h102, "R6 trigger beyond lines word1");
      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL scoreboard: %0d reads unanswered, actual pending expected 0", sb_q.size());
      end
      finish_run();
   end
endmodule